// File: doc/BRIEF.md
# System-Control Trap and Interrupt Unit

This unit is the system-control register file of a small MIPS-style processor core. It holds sixteen 32-bit registers. Software accesses them through an indexed write port and an indexed read port. Every software write passes through a mask chosen by the register index, so each register keeps only the bits software may change.

The unit watches a status word and a cause word and decides each cycle whether an interrupt is due. The cause word carries two software-raised pending bits and one pending bit driven by external hardware lines. When an interrupt is due, or when the pipeline requests a synchronous exception, the unit records a trap in a single cycle:
- it rewrites the low cause field and the delay-slot flag;
- it computes the return address from the current program counter;
- it pushes the status enable/mode stack.

For an interrupt it also sends a take strobe back to the pipeline, which then skips its normal step.

Top module: `cp0x_sysctl`

## Requirements
- R1: Software writes to indices 3, 5, 9, 11 and 12 store all 32 bits. Writes to indices 0, 1, 2, 4, 6, 8, 10 and 14 have no effect, and indices 0, 1, 2, 4, 6, 8 and 10 read as zero.
- R2: A software write to index 7 stores only the bits set in 0xFFC0F03F. The other bits read as zero.
- R3: On index 13 (cause), software can change only bits 8 and 9. Bit 10 always equals the OR of the `hw_irq` lines sampled at the previous clock edge, whatever software writes.
- R4: `rd_data` shows, one clock after `rd_idx` is presented, the register value as it stood before that edge. Index 15 reads the parameter `PRID_VALUE`, and writes to it have no effect.
- R5: An interrupt is taken at a clock edge when status bit 0 is 1 and (status AND cause AND 0x00000700) is nonzero. `irq_take` is high for the cycle that follows that edge.
- R6: On any trap, cause bits 6:0 are cleared and bits 6:2 receive the exception code. The code is 0 for an interrupt and `exc_code` otherwise. Cause bits 30:7 are unaffected by the trap.
- R7: On a trap, index 14 (return address) is loaded with `pc` − 4 for an interrupt and with `pc` − 8 for any other exception.
- R8: If `in_delay_slot` is 1 during the trap cycle, the return address is a further 4 lower and cause bit 31 is set. Otherwise cause bit 31 is cleared.
- R9: On a trap, status bits 5:0 become {old bits 3:0, 2'b00} and bits 31:6 are kept. As a result, a taken interrupt leaves status bit 0 clear.
- R10: When an interrupt is due in the same cycle as `exc_req`, the interrupt is recorded (code 0, `pc` − 4) and `irq_take` is raised.
- R11: A software write presented in a cycle in which a trap is taken is discarded.
- R12: Synchronous reset clears status, cause, return address, `rd_data` and `irq_take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_idx | input | 4 | Register index for the write |
| wr_data | input | 32 | Write data, masked per index |
| rd_idx | input | 4 | Register index for the read |
| rd_data | output | 32 | Registered read data |
| hw_irq | input | HW_LINES | External interrupt lines, ORed into cause bit 10 |
| pc | input | 32 | Program counter of the current instruction |
| in_delay_slot | input | 1 | Current instruction sits in a branch delay slot |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Exception code for `exc_req` |
| irq_take | output | 1 | Interrupt accepted at the previous edge |

## Verification
The assertions assume that `pc` and `in_delay_slot` describe the instruction in the same cycle as the trap decision. They also assume that `exc_req` is a one-cycle pulse, so that the sampled program counter is the one the return address was computed from. The stimulus changes inputs only on falling edges, holds `pc` and the delay-slot flag steady through each trap, and pulses `exc_req` for exactly one cycle. During the mask sweeps it keeps `hw_irq` low and the cause pending bits clear, so no interrupt fires by accident.

// File: rtl/cp0x_pkg.sv
package cp0x_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_REGS = 16;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned HW_BIT   = 10;
  localparam int unsigned BD_BIT   = 31;
  localparam int unsigned IE_BIT   = 0;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [CODE_W-1:0] code_t;

  localparam idx_t IX_BPCTL  = idx_t'(7);
  localparam idx_t IX_STATUS = idx_t'(12);
  localparam idx_t IX_CAUSE  = idx_t'(13);
  localparam idx_t IX_EPC    = idx_t'(14);
  localparam idx_t IX_PRID   = idx_t'(15);

  localparam word_t IRQ_FIELD  = 32'h0000_0700;
  localparam word_t LOW_FIELD  = 32'h0000_007F;
  localparam word_t BPCTL_MASK = 32'hFFC0_F03F;
  localparam word_t CAUSE_MASK = 32'h0000_0300;

  // Bits that software may change, by register index.
  function automatic word_t write_mask(input idx_t idx);
    word_t m;
    case (idx)
      idx_t'(3), idx_t'(5), idx_t'(9), idx_t'(11), IX_STATUS: m = '1;
      IX_BPCTL: m = BPCTL_MASK;
      IX_CAUSE: m = CAUSE_MASK;
      default:  m = '0;
    endcase
    return m;
  endfunction

  typedef struct packed {
    word_t status;
    word_t cause;
    word_t epc;
  } trap_state_t;

endpackage

// File: rtl/cp0x_bp_bank.sv
// Plain storage for the low, fully software-owned registers.
// One write port and one registered read port, so it maps to block RAM.
module cp0x_bp_bank #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cp0x_irq_detect.sv
// Decides whether an enabled, unmasked interrupt is pending.
module cp0x_irq_detect
  import cp0x_pkg::*;
#(
  parameter word_t       FIELD  = IRQ_FIELD,
  parameter int unsigned EN_BIT = IE_BIT
) (
  input  word_t status,
  input  word_t cause,
  output logic  pend
);

  word_t hits;

  always_comb begin
    hits = status & cause & FIELD;
    pend = status[EN_BIT] && (hits != '0);
  end

endmodule

// File: rtl/cp0x_trap_calc.sv
// Computes the register values written when a trap is taken.
module cp0x_trap_calc
  import cp0x_pkg::*;
#(
  parameter int unsigned STACK_BITS = 6,
  parameter int unsigned PUSH_STEP  = 2,
  parameter int unsigned IRQ_BACK   = 4,
  parameter int unsigned EXC_BACK   = 8,
  parameter int unsigned SLOT_BACK  = 4
) (
  input  word_t       pc,
  input  logic        in_slot,
  input  logic        is_irq,
  input  code_t       code,
  input  word_t       status,
  input  word_t       cause,
  output trap_state_t nxt
);

  word_t back;
  word_t c;
  word_t s;

  always_comb begin
    back = is_irq ? word_t'(IRQ_BACK) : word_t'(EXC_BACK);
    if (in_slot) begin
      back = back + word_t'(SLOT_BACK);
    end

    c = cause & ~LOW_FIELD;
    c[CODE_LSB +: CODE_W] = is_irq ? '0 : code;
    c[BD_BIT] = in_slot;

    s = status;
    s[STACK_BITS-1:0] = {status[STACK_BITS-PUSH_STEP-1:0], {PUSH_STEP{1'b0}}};

    nxt.epc    = pc - back;
    nxt.cause  = c;
    nxt.status = s;
  end

endmodule

// File: rtl/cp0x_sysctl.sv
module cp0x_sysctl
  import cp0x_pkg::*;
#(
  parameter int unsigned HW_LINES   = 1,
  parameter logic [31:0] PRID_VALUE = 32'h0000_0002
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [3:0]          wr_idx,
  input  logic [31:0]         wr_data,
  input  logic [3:0]          rd_idx,
  output logic [31:0]         rd_data,
  input  logic [HW_LINES-1:0] hw_irq,
  input  logic [31:0]         pc,
  input  logic                in_delay_slot,
  input  logic                exc_req,
  input  logic [4:0]          exc_code,
  output logic                irq_take
);

  localparam idx_t        BANK_TOP   = IX_STATUS;
  localparam int unsigned BANK_DEPTH = int'(BANK_TOP);

  word_t       status_q, cause_q, epc_q;
  word_t       status_d, cause_d, epc_d;
  logic        irq_take_q;
  logic        irq_pend;
  logic        trap_now;
  logic        sw_we;
  logic        bank_we;
  word_t       wmask_w;
  word_t       wr_masked;
  logic        hw_any;
  trap_state_t trap_nxt;
  idx_t        bank_raddr;
  word_t       bank_rd;
  word_t       spec_rd_q;
  logic        use_bank_q;

  cp0x_irq_detect u_irq (
    .status (status_q),
    .cause  (cause_q),
    .pend   (irq_pend)
  );

  cp0x_trap_calc u_trap (
    .pc      (pc),
    .in_slot (in_delay_slot),
    .is_irq  (irq_pend),
    .code    (exc_code),
    .status  (status_q),
    .cause   (cause_q),
    .nxt     (trap_nxt)
  );

  always_comb begin
    trap_now  = irq_pend | exc_req;
    sw_we     = wr_en & ~trap_now;
    wmask_w   = write_mask(wr_idx);
    wr_masked = wr_data & wmask_w;
    bank_we   = sw_we && (wr_idx < BANK_TOP) && (wmask_w != '0);
    hw_any    = |hw_irq;
  end

  // Next-state selection for the trap-owned registers.
  always_comb begin
    status_d = status_q;
    cause_d  = cause_q;
    epc_d    = epc_q;
    if (trap_now) begin
      status_d = trap_nxt.status;
      cause_d  = trap_nxt.cause;
      epc_d    = trap_nxt.epc;
    end else if (sw_we) begin
      if (wr_idx == IX_STATUS) begin
        status_d = (status_q & ~wmask_w) | wr_masked;
      end
      if (wr_idx == IX_CAUSE) begin
        cause_d = (cause_q & ~wmask_w) | wr_masked;
      end
    end
    cause_d[HW_BIT] = hw_any;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= '0;
      cause_q    <= '0;
      epc_q      <= '0;
      irq_take_q <= 1'b0;
    end else begin
      status_q   <= status_d;
      cause_q    <= cause_d;
      epc_q      <= epc_d;
      irq_take_q <= irq_pend;
    end
  end

  assign bank_raddr = (rd_idx < BANK_TOP) ? rd_idx : '0;

  cp0x_bp_bank #(
    .DEPTH (BANK_DEPTH),
    .WIDTH (WORD_W)
  ) u_bank (
    .clk   (clk),
    .we    (bank_we),
    .waddr (wr_idx),
    .wdata (wr_masked),
    .raddr (bank_raddr),
    .rdata (bank_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_rd_q  <= '0;
      use_bank_q <= 1'b0;
    end else begin
      use_bank_q <= (rd_idx < BANK_TOP) && (write_mask(rd_idx) != '0);
      case (rd_idx)
        IX_STATUS: spec_rd_q <= status_q;
        IX_CAUSE:  spec_rd_q <= cause_q;
        IX_EPC:    spec_rd_q <= epc_q;
        IX_PRID:   spec_rd_q <= PRID_VALUE;
        default:   spec_rd_q <= '0;
      endcase
    end
  end

  assign rd_data  = use_bank_q ? bank_rd : spec_rd_q;
  assign irq_take = irq_take_q;

  AST_TAKE_CLEARS_IE: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> !status_q[IE_BIT]);  // R9

  AST_IRQ_RETURN_ADDR: assert property (@(posedge clk) disable iff (rst)
    (irq_take && !$past(in_delay_slot)) |-> (epc_q == $past(pc) - 32'd4));  // R7

  AST_SLOT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (irq_take && $past(in_delay_slot)) |-> (cause_q[BD_BIT] && (epc_q == $past(pc) - 32'd8)));  // R8

  AST_IRQ_OVER_EXC: assert property (@(posedge clk) disable iff (rst)
    (irq_take && $past(exc_req)) |-> (cause_q[CODE_LSB +: CODE_W] == '0));  // R10

  AST_CAUSE_SW_FIELD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && (wr_idx == IX_CAUSE) && !exc_req && !irq_pend))
      |-> ((cause_q[31:11] == $past(cause_q[31:11])) && (cause_q[7:0] == $past(cause_q[7:0]))));  // R3

  AST_PRID_READ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(rd_idx) == IX_PRID)) |-> (rd_data == PRID_VALUE));  // R4

  AST_HW_PEND_TRACK: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cause_q[HW_BIT] == $past(|hw_irq)));  // R3

endmodule

// File: tb/cp0x_sysctl_test.sv
`timescale 1ns/1ps
module cp0x_sysctl_test;

  localparam logic [31:0] PRID = 32'h0000_0002;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [0:0]  hw_irq = '0;
  logic [31:0] pc = '0;
  logic        in_delay_slot = 1'b0;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic        irq_take;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  cp0x_sysctl #(.HW_LINES(1), .PRID_VALUE(PRID)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .hw_irq(hw_irq), .pc(pc),
    .in_delay_slot(in_delay_slot), .exc_req(exc_req), .exc_code(exc_code),
    .irq_take(irq_take)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] v);
    rd_idx = idx;
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic logic [31:0] exp_mask(input int i);
    case (i)
      3, 5, 9, 11, 12: return 32'hFFFF_FFFF;
      7:               return 32'hFFC0_F03F;
      13:              return 32'h0000_0300;
      default:         return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] pushed(input logic [31:0] s);
    return (s & ~32'h3F) | ((s << 2) & 32'h3F);
  endfunction

  // Set up one interrupt scenario and check whether it is taken.
  task automatic irq_case(input string tag, input logic [31:0] sr_val, input logic [31:0] cw,
                          input logic hw, input logic ds, input logic [31:0] pcv,
                          input logic expect_take);
    logic [31:0] v;
    wr(12, 32'h0);
    wr(13, cw);
    hw_irq = hw; pc = pcv; in_delay_slot = ds;
    @(negedge clk);
    wr(12, sr_val);
    @(negedge clk);
    check({tag, " R5 take"}, {31'b0, irq_take}, {31'b0, expect_take});
    @(negedge clk);
    check({tag, " R9 no retake"}, {31'b0, irq_take}, 32'h0);
    if (expect_take) begin
      rd(14, v);
      check({tag, " R7/R8 return addr"}, v, pcv - 32'd4 - (ds ? 32'd4 : 32'd0));
      rd(13, v);
      check({tag, " R6/R8 cause"}, v,
            (cw & 32'h300) | ({31'b0, hw} << 10) | ({31'b0, ds} << 31));
      rd(12, v);
      check({tag, " R9 status push"}, v, pushed(sr_val));
    end
    hw_irq = '0; in_delay_slot = 1'b0;
    wr(12, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
    pats[2] = 32'hA5A5_A5A4; pats[3] = 32'h5A5A_5A5B;

    repeat (3) @(negedge clk);
    check("R12 rd_data in reset", rd_data, 32'h0);
    check("R12 irq_take in reset", {31'b0, irq_take}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    rd(12, v); check("R12 status after reset", v, 32'h0);
    rd(13, v); check("R12 cause after reset", v, 32'h0);
    rd(14, v); check("R12 return addr after reset", v, 32'h0);

    // Mask sweep over every index and several data patterns.
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 16; i++) begin
        if (i == 12) continue;
        wr(4'(i), pats[p]);
        rd(4'(i), v);
        if (i == 15)      check("R4 id register", v, PRID);
        else if (i == 14) check("R1 return addr write ignored", v, 32'h0);
        else if (i == 13) check("R3 cause software bits", v, pats[p] & exp_mask(i));
        else if (i == 7)  check("R2 breakpoint control mask", v, pats[p] & exp_mask(i));
        else              check("R1 write mask", v, pats[p] & exp_mask(i));
        if (i == 13) wr(13, 32'h0);
      end
      wr(12, pats[p]);
      rd(12, v);
      check("R1 status full write", v, pats[p]);
      wr(12, 32'h0);
    end

    // Hardware pending bit cannot be cleared by software.
    hw_irq = 1'b1;
    @(negedge clk);
    wr(13, 32'h0);
    rd(13, v);
    check("R3 hardware pending bit holds", v, 32'h0000_0400);
    hw_irq = 1'b0;
    @(negedge clk);
    rd(13, v);
    check("R3 hardware pending bit follows line", v, 32'h0);

    // Synchronous exceptions over every nonzero code, with and without delay slot.
    for (int code = 1; code < 32; code++) begin
      for (int ds = 0; ds < 2; ds++) begin
        logic [31:0] pcv;
        logic [31:0] sv;
        pcv = 32'h8000_1000 + 32'(code * 16);
        sv  = 32'h1234_00F5;
        wr(13, 32'h300);
        wr(12, sv);
        exc_req = 1'b1; exc_code = 5'(code); pc = pcv; in_delay_slot = ds[0];
        @(negedge clk);
        exc_req = 1'b0;
        check("R5 no take on exception", {31'b0, irq_take}, 32'h0);
        in_delay_slot = 1'b0;
        rd(14, v);
        check(ds ? "R8 slot return addr" : "R7 exception return addr", v,
              pcv - 32'd8 - (ds ? 32'd4 : 32'd0));
        rd(13, v);
        check(ds ? "R8 slot cause" : "R6 exception cause", v,
              32'h300 | (32'(code) << 2) | (32'(ds) << 31));
        rd(12, v);
        check("R9 status push on exception", v, pushed(sv));
      end
    end
    wr(12, 32'h0);

    // Interrupt scenarios.
    irq_case("hw line",         32'h0000_0401, 32'h000, 1'b1, 1'b0, 32'h0000_4000, 1'b1);
    irq_case("sw bit 8 slot",   32'h0000_0105, 32'h100, 1'b0, 1'b1, 32'h0000_5004, 1'b1);
    irq_case("sw bit 9",        32'h0000_0209, 32'h200, 1'b0, 1'b0, 32'h0000_6008, 1'b1);
    irq_case("IE clear",        32'h0000_0400, 32'h000, 1'b1, 1'b0, 32'h0000_7000, 1'b0);
    irq_case("masked hw",       32'h0000_0301, 32'h000, 1'b1, 1'b0, 32'h0000_7100, 1'b0);
    irq_case("no pending",      32'h0000_0701, 32'h000, 1'b0, 1'b0, 32'h0000_7200, 1'b0);

    // Interrupt and exception together, with a software write in the same cycle.
    wr(12, 32'h0);
    wr(13, 32'h0);
    wr(3, 32'h1111_1111);
    hw_irq = 1'b1; pc = 32'h0000_9000;
    @(negedge clk);
    wr(12, 32'h0000_0401);
    exc_req = 1'b1; exc_code = 5'd5;
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h2222_2222;
    @(negedge clk);
    exc_req = 1'b0; wr_en = 1'b0;
    check("R10 interrupt wins take", {31'b0, irq_take}, 32'h1);
    hw_irq = 1'b0;
    rd(13, v);
    check("R10 interrupt code", v, 32'h0000_0400);
    rd(14, v);
    check("R10 interrupt return addr", v, 32'h0000_8FFC);
    rd(3, v);
    check("R11 write dropped on trap", v, 32'h1111_1111);

    // Plain exception also drops a same-cycle write.
    wr(12, 32'h0);
    exc_req = 1'b1; exc_code = 5'd8; pc = 32'h0000_A000;
    wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h3333_3333;
    @(negedge clk);
    exc_req = 1'b0; wr_en = 1'b0;
    wr(5, 32'h4444_4444);
    rd(5, v);
    check("R11 later write lands", v, 32'h4444_4444);

    finish_run();
  end

endmodule